// File: doc/BRIEF.md
# Periodic Offset-Compare Event Timer

This block produces periodic interrupt and wakeup events without a counter of its own. It watches a shared free-running 32-bit count. When it is switched on, it forms a target equal to the present count plus a 10-bit interval. Each time the count equals that target, the block raises an event and at once re-arms the target. The new target is the count at the hit plus the interval, in wrapping 32-bit arithmetic.

A hit sets a sticky event flag. An interrupt request follows the flag while the interrupt enable is high. While the system sleeps and wakeup is enabled, a hit first pulses a wakeup request and records it in a sticky wake-capture flag. The event flag is set one cycle after that pulse. Software clears both flags with a single clear strobe. The interval may be rewritten at any moment. A new interval only changes the target computed at the next re-arm.

All pins are plain control and status signals. No data stream crosses the boundary, so the block has no valid/ready handshake and no back-pressure.

Top module: `periodic_tick_gen`

## Requirements
- R1: While rst_n is low and right after it rises, irq_o, wake_o, flag_o and wake_flag_o are all 0.
- R2: In a cycle where en_i is high and was low in the previous cycle, the target is loaded with cnt_i plus the step. The first event is the first later cycle, with en_i still high, in which cnt_i equals that target.
- R3: An event outside the deferred case of R6 sets flag_o at the next rising clock edge. In the same edge the target becomes cnt_i + step, computed modulo 2^32.
- R4: A one-cycle high on flag_clr_i clears both flag_o and wake_flag_o at the next edge. If a set of either flag falls in that same edge, the set wins.
- R5: irq_o is high exactly when flag_o is high and irq_en_i is high.
- R6: An event while sleep_i and wake_en_i are both high raises wake_o for one cycle after the next edge. flag_o is set one edge later than that.
- R7: wake_flag_o is set together with wake_o and stays set until it is cleared as in R4.
- R8: A change of interval_i leaves the pending target untouched. It only affects the target loaded at the next event or rising enable.
- R9: While en_i is low, no new event occurs. Raising en_i again loads a fresh target as in R2.
- R10: An interval_i of 0 acts as a step of 1, so the target is always ahead of the count at the hit.
- R11: Targets that cross from 0xFFFF_FFFF to 0 wrap, and the event falls at the wrapped count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 32 | Shared free-running count |
| en_i | input | 1 | Timer enable; a rising edge arms the first target |
| interval_i | input | 10 | Interval between events in count ticks (0 means 1) |
| irq_en_i | input | 1 | Interrupt enable |
| wake_en_i | input | 1 | Wakeup enable |
| sleep_i | input | 1 | System is in sleep |
| flag_clr_i | input | 1 | Clears the event and wake-capture flags |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | One-cycle wakeup request |
| flag_o | output | 1 | Sticky event flag |
| wake_flag_o | output | 1 | Sticky wakeup-capture flag |

## Verification
A corrupted target register shows at the ports as an event that arrives at the wrong count, or that never arrives. With a short interval this appears within a few cycles as a flag that rises early, late or not at all. A wrong enable history or a wrong deferral state shows as a flag that rises while disabled, or as a wake pulse that is missing or not followed one cycle later by the flag. The bench compares all four outputs in every cycle, so it sees such a fault at the first event after the fault occurs.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  parameter int unsigned CNT_W = 32;
  parameter int unsigned IVL_W = 10;

  typedef struct packed {
    logic hit;    // count reached the target this cycle
    logic defer;  // hit happened while sleeping with wakeup enabled
  } ptg_evt_t;
endpackage

// File: rtl/ptg_target.sv
module ptg_target #(
  parameter int unsigned CNT_W = ptg_pkg::CNT_W,
  parameter int unsigned IVL_W = ptg_pkg::IVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             en_i,
  input  logic [IVL_W-1:0] interval_i,
  output logic             hit_o
);
  localparam int unsigned PAD_W = CNT_W - IVL_W;

  logic             en_q;
  logic [CNT_W-1:0] target_q;
  logic [CNT_W-1:0] step;
  logic             arm_rise;
  logic             load;

  // zero interval counts as one tick so the target is never behind the count
  always_comb begin
    step = {{PAD_W{1'b0}}, interval_i};
    if (interval_i == '0) step = {{(CNT_W-1){1'b0}}, 1'b1};
  end

  assign arm_rise = en_i & ~en_q;
  assign hit_o    = en_i & en_q & (cnt_i == target_q);
  assign load     = arm_rise | hit_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      target_q <= '0;
    end else begin
      en_q <= en_i;
      if (load) target_q <= cnt_i + step;  // wraps modulo 2^CNT_W
    end
  end

  // R10: a re-arm always moves the target
  a_r10_target_moves: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> (target_q != $past(target_q)));

  // R8: without an arm or a hit, the pending target holds
  a_r8_target_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_o && !arm_rise) |=> $stable(target_q));
endmodule

// File: rtl/ptg_flags.sv
module ptg_flags
  import ptg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ptg_evt_t evt_i,
  input  logic     clr_i,
  output logic     flag_o,
  output logic     wake_o,
  output logic     wake_flag_o
);
  logic flag_q, wake_q, wflag_q, pend_q;
  logic flag_set;

  // a deferred hit sets the flag one cycle after the wake pulse
  assign flag_set = (evt_i.hit & ~evt_i.defer) | pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      wake_q  <= 1'b0;
      wflag_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      wake_q <= evt_i.defer;
      pend_q <= evt_i.defer;
      if (flag_set)   flag_q  <= 1'b1;
      else if (clr_i) flag_q  <= 1'b0;
      if (evt_i.defer) wflag_q <= 1'b1;
      else if (clr_i)  wflag_q <= 1'b0;
    end
  end

  assign flag_o      = flag_q;
  assign wake_o      = wake_q;
  assign wake_flag_o = wflag_q;

  // R6: a wake pulse is followed by the event flag
  a_r6_flag_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> flag_q);

  // R7: the capture flag is set whenever a wake pulse is present
  a_r7_wake_captured: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> wflag_q);

  // R4: a clear with nothing to set leaves the flag low
  a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !flag_set) |=> !flag_q);

  // R9: the flag rises only after a hit or a pending deferred set
  a_r9_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i.hit && !pend_q) |=> !$rose(flag_q));
endmodule

// File: rtl/periodic_tick_gen.sv
module periodic_tick_gen
  import ptg_pkg::*;
#(
  parameter int unsigned CNT_W_P = ptg_pkg::CNT_W,
  parameter int unsigned IVL_W_P = ptg_pkg::IVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W_P-1:0] cnt_i,
  input  logic               en_i,
  input  logic [IVL_W_P-1:0] interval_i,
  input  logic               irq_en_i,
  input  logic               wake_en_i,
  input  logic               sleep_i,
  input  logic               flag_clr_i,
  output logic               irq_o,
  output logic               wake_o,
  output logic               flag_o,
  output logic               wake_flag_o
);
  logic     hit;
  ptg_evt_t evt;

  ptg_target #(.CNT_W(CNT_W_P), .IVL_W(IVL_W_P)) u_target (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_i      (cnt_i),
    .en_i       (en_i),
    .interval_i (interval_i),
    .hit_o      (hit)
  );

  assign evt.hit   = hit;
  assign evt.defer = hit & sleep_i & wake_en_i;

  ptg_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt),
    .clr_i       (flag_clr_i),
    .flag_o      (flag_o),
    .wake_o      (wake_o),
    .wake_flag_o (wake_flag_o)
  );

  assign irq_o = flag_o & irq_en_i;

  // R5: an interrupt request never appears without the flag
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o);
endmodule

// File: tb/periodic_tick_gen_bench.sv
`timescale 1ns/1ps
module periodic_tick_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cnt;
  logic        en, ien, wen, slp, clr;
  logic [9:0]  iv;
  logic        irq_o, wake_o, flag_o, wake_flag_o;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  // bench model state
  bit          m_en_q, m_flag, m_wflag, m_pend, m_wake;
  logic [31:0] m_target;

  always #2 clk = ~clk;  // 250 MHz

  periodic_tick_gen u_periodic_tick_gen (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .en_i(en), .interval_i(iv),
    .irq_en_i(ien), .wake_en_i(wen), .sleep_i(slp), .flag_clr_i(clr),
    .irq_o(irq_o), .wake_o(wake_o), .flag_o(flag_o), .wake_flag_o(wake_flag_o)
  );

  function automatic logic [31:0] step_of(input logic [9:0] v);
    return (v == 10'd0) ? 32'd1 : {22'd0, v};  // R10
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b cnt=%0h", tag, act, exp, cnt);
    end
  endtask

  // one cycle: inputs already driven; predict, clock, compare
  task automatic cyc(input string tag);
    bit hit, dfr, n_flag, n_wflag;
    hit     = en && m_en_q && (cnt == m_target);
    dfr     = hit && slp && wen;
    n_flag  = ((hit && !dfr) || m_pend) ? 1'b1 : (clr ? 1'b0 : m_flag);
    n_wflag = dfr ? 1'b1 : (clr ? 1'b0 : m_wflag);
    if ((en && !m_en_q) || hit) m_target = cnt + step_of(iv);  // R2 R3 R11
    m_en_q = en;
    m_pend = dfr;
    m_wake = dfr;
    m_flag = n_flag;
    m_wflag = n_wflag;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " flag_o"}, flag_o, m_flag);
    chk("R6 wake_o", wake_o, m_wake);
    chk("R7 wake_flag_o", wake_flag_o, m_wflag);
    chk("R5 irq_o", irq_o, m_flag & ien);
  endtask

  task automatic run(input string tag, input int n, input bit rnd_clr, input bit rnd_iv);
    for (int i = 0; i < n; i++) begin
      clr = rnd_clr ? ($urandom_range(0, 7) == 0) : 1'b0;
      if (rnd_iv && ($urandom_range(0, 3) == 0)) iv = 10'($urandom_range(0, 12));
      cyc(tag);
      if ($urandom_range(0, 4) != 0) cnt = cnt + 32'd1;  // occasional stall
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cnt = 32'd1000; en = 1'b0; iv = 10'd5;
    ien = 1'b1; wen = 1'b0; slp = 1'b0; clr = 1'b0;
    m_en_q = 0; m_flag = 0; m_wflag = 0; m_pend = 0; m_wake = 0; m_target = '0;
    repeat (3) @(negedge clk);
    chk("R1 flag_o", flag_o, 1'b0);
    chk("R1 wake_o", wake_o, 1'b0);
    chk("R1 irq_o", irq_o, 1'b0);
    chk("R1 wake_flag_o", wake_flag_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flag_o after release", flag_o, 1'b0);

    // R2 R3: arm and run a fixed interval
    en = 1'b1;
    run("R2", 40, 1'b0, 1'b0);
    run("R3", 60, 1'b1, 1'b0);
    // R4 R5: clears and toggled irq enable
    for (int i = 0; i < 60; i++) begin
      ien = $urandom_range(0, 1);
      clr = ($urandom_range(0, 3) == 0);
      cyc("R4");
      cnt = cnt + 32'd1;
    end
    ien = 1'b1;
    // R6 R7: sleeping with wakeup enabled
    slp = 1'b1; wen = 1'b1; iv = 10'd3;
    run("R6", 80, 1'b1, 1'b0);
    slp = 1'b0; wen = 1'b0;
    // R8: interval rewritten while running
    run("R8", 200, 1'b1, 1'b1);
    // R9: disabled, then cleared, no events
    en = 1'b0; iv = 10'd1;
    clr = 1'b1; cyc("R9"); clr = 1'b0;
    for (int i = 0; i < 40; i++) begin cyc("R9"); cnt = cnt + 32'd1; end
    en = 1'b1;
    run("R9", 30, 1'b0, 1'b0);
    // R10: zero interval gives a hit every tick
    iv = 10'd0;
    for (int i = 0; i < 30; i++) begin clr = i[0]; cyc("R10"); cnt = cnt + 32'd1; end
    // R11: rollover of the shared count
    en = 1'b0; cyc("R11");
    cnt = 32'hFFFF_FFF0; iv = 10'd7; en = 1'b1;
    run("R11", 60, 1'b1, 1'b0);
    // mixed random
    for (int i = 0; i < 3000; i++) begin
      ien = ($urandom_range(0, 3) != 0);
      slp = $urandom_range(0, 1);
      wen = $urandom_range(0, 1);
      clr = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 50) == 0) en = ~en;
      if ($urandom_range(0, 9) == 0) iv = 10'($urandom_range(0, 20));
      if ($urandom_range(0, 199) == 0) iv = 10'($urandom_range(0, 1023));
      cyc("R8 mix");
      if ($urandom_range(0, 4) != 0) cnt = cnt + 32'd1;
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule